// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Error-Tagged Buffer

This block takes one asynchronous serial input line and turns it into bytes for a host. A one-cycle enable, pulsed at sixteen times the bit rate, paces the line sampling. The block confirms each start bit and collects 5 to 8 data bits, least significant first. It then optionally checks a parity bit and samples the stop bit. Each finished character goes into a 16-entry buffer together with three error tags.

The host drains the buffer with a one-cycle read strobe. The oldest character and its tags are always visible on the read outputs before the strobe. Two interrupt outputs tell the host when to read. The first reports that the buffer fill has reached a chosen threshold. The second reports that characters have sat unread for about four character times.

A sticky flag records any character lost because the buffer was full. A status-clear strobe resets that flag.

Top module: `serial_rx_channel`

## Requirements
- R1: A character begins only on a high-to-low transition of the synchronised line. The line is sampled again on the 8th tick after that transition: low confirms the start bit, and high returns the block to idle without storing anything.
- R2: Data bits are taken one per 16 ticks, least significant bit first. The count is set by `cfg_wlen` (00=5, 01=6, 10=7, 11=8 bits), and unused upper bits of `rd_data` read as zero.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 expects an even total count of ones over data plus parity, and 0 expects an odd total. A mismatch sets `rd_err[0]`.
- R4: A stop bit sampled low sets `rd_err[1]` (framing). `rd_err[2]` (break) is set when the data bits, the parity bit if enabled, and the stop bit are all low.
- R5: The buffer holds 16 characters of 8 data bits plus 3 tags, and returns them in arrival order. `rd_data`/`rd_err` show the oldest entry, and `rd_stb` removes it.
- R6: `data_ready` rises once a character is stored. It falls only when a read empties the buffer.
- R7: `irq_trigger` is high while the stored count is at or above the level picked by `cfg_trig` (00=1, 01=4, 10=8, 11=14) and `cfg_rx_irq_en`=1. It falls as soon as the count drops below that level.
- R8: `irq_timeout` rises, with `cfg_rx_irq_en`=1, after the buffer has held data without a read or write for (4 × (start + data + parity + stop bits) + 12) × 16 ticks.
- R9: A read clears `irq_timeout` and restarts the time-out count. A newly stored character also restarts the count.
- R10: A character that completes while the buffer is full is dropped, the stored entries stay unchanged, and `overrun` is set. `overrun` holds until `ovr_clr` is pulsed.
- R11: After reset, `data_ready`, `overrun`, `irq_trigger` and `irq_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable at 16× the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Data-bit count code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Parity type: 1 even, 0 odd |
| cfg_trig | input | 2 | Fill-threshold code |
| cfg_rx_irq_en | input | 1 | Enables both interrupts |
| rd_stb | input | 1 | Host read strobe, pops one character |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest stored character |
| rd_err | output | 3 | Tags of the oldest character {break, framing, parity} |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky lost-character flag |
| irq_trigger | output | 1 | Fill-threshold interrupt |
| irq_timeout | output | 1 | Character time-out interrupt |

## Verification
The hardest state to reach is a time-out restarted by a new character rather than by a read. That case needs a second frame whose final write lands after most of the first character's window has passed. The bench spaces frames so that the window since the first write has long expired before the interrupt is sampled. It then shows the interrupt firing a full window after the second write. Overrun needs seventeen complete frames without reads. The bench fills the buffer and then checks every surviving entry in order, confirming that the dropped frame did not disturb them.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int OVS    = 16;
   localparam int DATA_W = 8;
   localparam int ERR_W  = 3;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_err_t;

   typedef struct packed {
      logic [DATA_W-1:0] data;
      rx_err_t           err;
   } rx_word_t;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_PAR,
      FR_STOP
   } fr_state_t;

   function automatic logic [7:0] trig_level(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd1;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd14;
      endcase
   endfunction

   function automatic logic [15:0] timeout_ticks(input logic [1:0] wl, input logic pen);
      logic [15:0] bits;
      bits = 16'd7 + {14'd0, wl} + {15'd0, pen};
      return (bits * 16'd4 + 16'd12) * 16'(OVS);
   endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_in,
   input  logic [1:0] wlen,
   input  logic       par_en,
   input  logic       par_even,
   output logic       frame_vld,
   output rx_word_t   frame
);

   localparam int PHW = $clog2(OVS);
   localparam logic [PHW-1:0] PH_MID  = PHW'(OVS / 2 - 1);
   localparam logic [PHW-1:0] PH_LAST = PHW'(OVS - 1);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("srx_framer: oversampling factor must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("srx_framer: SYNC_STAGES out of range");
   end

   logic rx_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '1;
         end else begin
            sr[0] <= rx_in;
            for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign rx_s = sr[SYNC_STAGES-1];
   end

   fr_state_t         st;
   logic [PHW-1:0]    ph;
   logic [2:0]        nb;
   logic [DATA_W-1:0] sh;
   logic              rx_prev;
   logic              pbit;

   logic [DATA_W-1:0] data_al;
   logic [2:0]        nb_last;
   logic              par_exp;
   rx_err_t           err_n;

   always_comb begin
      data_al   = sh >> (2'd3 - wlen);
      nb_last   = 3'd4 + {1'b0, wlen};
      par_exp   = (^data_al) ^ ~par_even;
      err_n.par = par_en && (pbit != par_exp);
      err_n.frm = !rx_s;
      err_n.brk = (data_al == '0) && !(par_en && pbit) && !rx_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         ph        <= '0;
         nb        <= '0;
         sh        <= '0;
         rx_prev   <= 1'b1;
         pbit      <= 1'b0;
         frame_vld <= 1'b0;
         frame     <= '0;
      end else begin
         frame_vld <= 1'b0;
         if (tick) begin
            rx_prev <= rx_s;
            case (st)
               FR_IDLE: begin
                  if (rx_prev && !rx_s) begin
                     st <= FR_START;
                     ph <= '0;
                  end
               end
               FR_START: begin
                  if (ph == PH_MID) begin
                     ph <= '0;
                     if (!rx_s) begin
                        st <= FR_DATA;
                        nb <= '0;
                        sh <= '0;
                     end else begin
                        st <= FR_IDLE;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               FR_DATA: begin
                  if (ph == PH_LAST) begin
                     ph <= '0;
                     sh <= {rx_s, sh[DATA_W-1:1]};
                     if (nb == nb_last) st <= par_en ? FR_PAR : FR_STOP;
                     else               nb <= nb + 1'b1;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               FR_PAR: begin
                  if (ph == PH_LAST) begin
                     ph   <= '0;
                     pbit <= rx_s;
                     st   <= FR_STOP;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               FR_STOP: begin
                  if (ph == PH_LAST) begin
                     ph         <= '0;
                     frame_vld  <= 1'b1;
                     frame.data <= data_al;
                     frame.err  <= err_n;
                     st         <= FR_IDLE;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               default: st <= FR_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_tag_fifo.sv
module srx_tag_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 11,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("srx_tag_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_wr, do_rd;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/srx_irq.sv
module srx_irq
   import srx_pkg::*;
#(
   parameter int CW = 5,
   parameter int TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] count,
   input  logic          wr_evt,
   input  logic          rd_evt,
   input  logic [1:0]    wlen,
   input  logic          par_en,
   input  logic [1:0]    trig_code,
   input  logic          irq_en,
   output logic          irq_trig,
   output logic          irq_to
);

   if (TW < 10) begin : g_bad_tw
      $error("srx_irq: timer too narrow for the longest time-out window");
   end

   logic [TW-1:0] tmr;
   logic [TW-1:0] limit;
   logic          to_flag;
   logic          has_data;

   assign has_data = (count != '0);
   assign limit    = TW'(timeout_ticks(wlen, par_en));
   assign irq_trig = irq_en && (count >= CW'(trig_level(trig_code)));
   assign irq_to   = irq_en && to_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr     <= '0;
         to_flag <= 1'b0;
      end else begin
         if (!has_data || rd_evt || wr_evt) tmr <= '0;
         else if (tick && !to_flag)         tmr <= tmr + 1'b1;

         if (!has_data || rd_evt)
            to_flag <= 1'b0;
         else if (tick && !wr_evt && tmr == limit - 1'b1)
            to_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
   import srx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMR_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rx_line,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic [1:0]        cfg_trig,
   input  logic              cfg_rx_irq_en,
   input  logic              rd_stb,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic [ERR_W-1:0]  rd_err,
   output logic              data_ready,
   output logic              overrun,
   output logic              irq_trigger,
   output logic              irq_timeout
);

   localparam int CW = $clog2(DEPTH) + 1;
   localparam int WW = $bits(rx_word_t);

   if (DEPTH < 14) begin : g_bad_depth
      $error("serial_rx_channel: DEPTH must cover the highest fill threshold");
   end

   logic          frame_vld;
   rx_word_t      frame;
   rx_word_t      head;
   logic [CW-1:0] count;
   logic          full, empty;
   logic          wr_evt, rd_evt;

   srx_framer #(.SYNC_STAGES(SYNC_STAGES)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .rx_in    (rx_line),
      .wlen     (cfg_wlen),
      .par_en   (cfg_par_en),
      .par_even (cfg_par_even),
      .frame_vld(frame_vld),
      .frame    (frame)
   );

   assign wr_evt = frame_vld && !full;
   assign rd_evt = rd_stb && !empty;

   srx_tag_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (frame_vld),
      .wr_data(frame),
      .rd_en  (rd_stb),
      .rd_data(head),
      .count  (count),
      .full   (full),
      .empty  (empty)
   );

   srx_irq #(.CW(CW), .TW(TMR_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .count    (count),
      .wr_evt   (wr_evt),
      .rd_evt   (rd_evt),
      .wlen     (cfg_wlen),
      .par_en   (cfg_par_en),
      .trig_code(cfg_trig),
      .irq_en   (cfg_rx_irq_en),
      .irq_trig (irq_trigger),
      .irq_to   (irq_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 overrun <= 1'b0;
      else if (frame_vld && full) overrun <= 1'b1;
      else if (ovr_clr)           overrun <= 1'b0;
   end

   assign rd_data    = head.data;
   assign rd_err     = head.err;
   assign data_ready = !empty;

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
   input logic clk,
   input logic rst_n,
   input logic rd_stb,
   input logic ovr_clr,
   input logic cfg_rx_irq_en,
   input logic data_ready,
   input logic overrun,
   input logic irq_trigger,
   input logic irq_timeout
);

   // R6: data_ready only falls through a read
   a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready && !rd_stb |=> data_ready);

   // R7: both interrupts are gated by the enable
   a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rx_irq_en |-> !irq_trigger && !irq_timeout);

   // R7: a fill threshold of at least one implies stored data
   a_r7_trig_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq_trigger |-> data_ready);

   // R8: a time-out needs stored data
   a_r8_timeout_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timeout |-> data_ready);

   // R9: a read clears the time-out
   a_r9_read_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && data_ready |=> !irq_timeout);

   // R10: overrun is sticky until cleared
   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !ovr_clr |=> overrun);

endmodule

bind serial_rx_channel srx_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_stb       (rd_stb),
   .ovr_clr      (ovr_clr),
   .cfg_rx_irq_en(cfg_rx_irq_en),
   .data_ready   (data_ready),
   .overrun      (overrun),
   .irq_trigger  (irq_trigger),
   .irq_timeout  (irq_timeout)
);

// File: tb/serial_rx_channel_test.sv
module serial_rx_channel_test;

   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b1;
   logic [1:0] cfg_trig = 2'd1;
   logic       cfg_rx_irq_en = 1'b1;
   logic       rd_stb = 1'b0;
   logic       ovr_clr = 1'b0;
   logic [7:0] rd_data;
   logic [2:0] rd_err;
   logic       data_ready, overrun, irq_trigger, irq_timeout;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   serial_rx_channel uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
      .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_trig(cfg_trig), .cfg_rx_irq_en(cfg_rx_irq_en), .rd_stb(rd_stb),
      .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_err(rd_err),
      .data_ready(data_ready), .overrun(overrun), .irq_trigger(irq_trigger),
      .irq_timeout(irq_timeout)
   );

   // {wlen, par_en, par_even, par_flip, stop, data, exp_data, exp_err{brk,frm,par}}
   localparam logic [24:0] VEC [9] = '{
      {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'hA5, 3'b000},
      {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3F, 8'h1F, 3'b000},
      {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h2A, 8'h2A, 3'b000},
      {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'h55, 3'b000},
      {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h03, 8'h03, 3'b000},
      {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h07, 8'h07, 3'b001},
      {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h81, 3'b010},
      {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 3'b110},
      {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 8'h10, 3'b000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                             input logic peven, input logic pflip, input logic stop);
      int nbits = 5 + int'(wl);
      logic pb = 1'b0;
      rx_line = 1'b0;
      idle(BIT_CLKS);
      for (int i = 0; i < nbits; i++) begin
         rx_line = d[i];
         pb ^= d[i];
         idle(BIT_CLKS);
      end
      if (pen) begin
         rx_line = (peven ? pb : ~pb) ^ pflip;
         idle(BIT_CLKS);
      end
      rx_line = stop;
      idle(BIT_CLKS);
      rx_line = 1'b1;
      idle(4);
   endtask

   task automatic read_one(output logic [7:0] d, output logic [2:0] e);
      d = rd_data;
      e = rd_err;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [2:0] e;
      idle(3);
      // R11: reset state
      check("R11 data_ready", 32'(data_ready), 0);
      check("R11 overrun", 32'(overrun), 0);
      check("R11 irq_trigger", 32'(irq_trigger), 0);
      check("R11 irq_timeout", 32'(irq_timeout), 0);
      rst_n = 1'b1;
      idle(4);

      // R2 R3 R4 R5: vector table, one frame per row
      for (int v = 0; v < 9; v++) begin
         logic [24:0] t = VEC[v];
         cfg_wlen = t[24:23];
         cfg_par_en = t[22];
         cfg_par_even = t[21];
         idle(2);
         send_frame(t[18:11], t[24:23], t[22], t[21], t[20], t[19]);
         check("R6 ready after frame", 32'(data_ready), 1);
         read_one(d, e);
         check("R2 data", 32'(d), 32'(t[10:3]));
         check("R3 R4 tags", 32'(e), 32'(t[2:0]));
         check("R6 ready after drain", 32'(data_ready), 0);
      end

      // R1: short low pulse is rejected
      cfg_wlen = 2'd3; cfg_par_en = 1'b0;
      rx_line = 1'b0; idle(4); rx_line = 1'b1;
      idle(200);
      check("R1 glitch rejected", 32'(data_ready), 0);

      // R7: threshold 4
      cfg_trig = 2'd1;
      for (int i = 0; i < 3; i++) send_frame(8'(i), 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R7 below level", 32'(irq_trigger), 0);
      send_frame(8'h33, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R7 at level", 32'(irq_trigger), 1);
      cfg_rx_irq_en = 1'b0; idle(1);
      check("R7 gated off", 32'(irq_trigger), 0);
      cfg_rx_irq_en = 1'b1; idle(1);
      read_one(d, e);
      check("R7 falls below level", 32'(irq_trigger), 0);
      read_one(d, e); read_one(d, e); read_one(d, e);
      check("R5 order after drain", 32'(d), 32'h33);

      // R8: time-out window 832 ticks for 8 bits, no parity
      send_frame(8'h41, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      idle(700);
      check("R8 not yet", 32'(irq_timeout), 0);
      idle(200);
      check("R8 fired", 32'(irq_timeout), 1);
      read_one(d, e);
      check("R9 read clears", 32'(irq_timeout), 0);
      check("R5 data", 32'(d), 32'h41);

      // R9: a new character restarts the timer
      send_frame(8'h51, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      idle(600);
      send_frame(8'h52, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      idle(500);
      check("R9 write restarts", 32'(irq_timeout), 0);
      idle(400);
      check("R8 fires after write", 32'(irq_timeout), 1);
      read_one(d, e);
      check("R9 cleared with data left", 32'(irq_timeout), 0);
      check("R6 ready with one left", 32'(data_ready), 1);
      idle(700);
      check("R9 timer restarted", 32'(irq_timeout), 0);
      idle(200);
      check("R9 fires again", 32'(irq_timeout), 1);
      read_one(d, e);
      check("R9 empty clears", 32'(irq_timeout), 0);

      // R10: overrun with 17 frames, threshold 14
      cfg_trig = 2'd3;
      for (int i = 0; i < 13; i++) send_frame(8'(8'h80 + i), 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R7 level 14 below", 32'(irq_trigger), 0);
      send_frame(8'h8D, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R7 level 14 reached", 32'(irq_trigger), 1);
      send_frame(8'h8E, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      send_frame(8'h8F, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
      check("R10 no overrun at 16", 32'(overrun), 0);
      send_frame(8'hEE, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R10 overrun set", 32'(overrun), 1);
      idle(20);
      check("R10 overrun sticky", 32'(overrun), 1);
      ovr_clr = 1'b1; idle(1); ovr_clr = 1'b0;
      check("R10 overrun cleared", 32'(overrun), 0);
      for (int i = 0; i < 16; i++) begin
         read_one(d, e);
         check("R10 R5 entry kept", 32'({e, d}), 32'({3'b000, 8'(8'h80 + i)}));
         if (i == 2)  check("R7 drop below 14", 32'(irq_trigger), 0);
         if (i == 14) check("R6 ready with one", 32'(data_ready), 1);
      end
      check("R6 ready cleared", 32'(data_ready), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule